// File: doc/BRIEF.md
# Column Burst Command Sequencer

This block sits on the controller side of a low-power double-data-rate memory interface. It turns column read and write requests into command words on a 10-bit command/address bus and drives a separate word for each clock edge. One request carries the access type, an 11-bit starting column and a burst length of 4, 8 or 16 beats. The block also tracks the burst in flight and decides whether a new request may cut into it. A request that is not yet allowed is held off with `req_ready` low. It is never discarded.

For read bursts the block counts the programmed read latency in clock cycles. It raises a one-cycle strobe-preamble flag, followed by a data-valid window that lasts one clock per two beats. The physical layer serializes `ca_rise` and `ca_fall` onto the two edges of the clock. The data path and the fine strobe timing stay outside this block.

Top module: `colburst_seq`

## Requirements
- R1: After reset `cs_n` is 1, both CA words are 10'h3FF, `rd_valid` and `dqs_preamble` are 0, and `req_ready` is 1.
- R2: In every cycle without a command, `cs_n` is 1 and both `ca_rise` and `ca_fall` equal 10'h3FF.
- R3: In the cycle after an accepting edge (`req_valid` and `req_ready` both high), `cs_n` is 0 and `ca_rise` bit 0 is 1 and bit 1 is 0. Bit 2 is 1 for a read and 0 for a write, and bits 3, 4, 7, 8 and 9 are 0.
- R4: Column packing in that cycle: `ca_rise[6:5]` = col[1:0], `ca_fall[9:1]` = col[10:2] and `ca_fall[0]` = 0.
- R5: Commands are spaced by at least 2 cycles. `req_ready` is 0 in the cycle that follows an accepting edge.
- R6: A burst of length 4 (`req_bl`=2'b00) is never cut into. A request of the other access type waits until the running burst has finished, which takes BL/2 cycles after its accepting edge.
- R7: A running 8-beat (`req_bl`=2'b01) or 16-beat (`req_bl`=2'b10 or 2'b11) burst may be interrupted by a request of the same type. The interrupt is allowed only at an even number of cycles, at least 2, after its accepting edge. Such a request is not accepted at an odd cycle count.
- R8: A held request stays pending until it becomes legal. It is then issued with its own type and column.
- R9: For a read accepted at edge k with latency RL, `rd_valid` is 1 in the cycles after edges k+RL through k+RL+BL/2-1.
- R10: `dqs_preamble` is 1 in exactly the cycle before a `rd_valid` window starts, and only if `rd_valid` is 0 in that cycle.
- R11: An accepted interrupting read restarts the window from its own command. Any remainder of the older window past the new window's end is dropped.
- R12: Write commands never raise `rd_valid` or `dqs_preamble`.
- R13: `rl_cfg` is sampled at the accepting edge. Later changes do not move a pending window. Values 0 and above MAX_RL are clamped to 1 and MAX_RL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| rl_cfg | input | RL_W (5) | Read latency in clock cycles |
| req_valid | input | 1 | Request present |
| req_is_read | input | 1 | 1 = read, 0 = write |
| req_col | input | 11 | Starting column address |
| req_bl | input | 2 | Burst length code: 00=4, 01=8, 1x=16 |
| req_ready | output | 1 | Request may be accepted at this edge |
| cs_n | output | 1 | Chip select, active low |
| ca_rise | output | 10 | Command/address word for the rising edge |
| ca_fall | output | 10 | Command/address word for the falling edge |
| dqs_preamble | output | 1 | Read strobe preamble flag |
| rd_valid | output | 1 | Read data-valid window |

## Verification
The bound checker watches several properties on every cycle. An idle bus must carry the no-operation word, and a selected bus must carry the column-command code. An accepted request must appear on the bus in the next cycle with its access type. No two commands may sit in adjacent cycles. Each preamble must be followed by a valid cycle.

Some properties depend on request history, and only the directed scenarios can show them. These are the exact stall counts for same-type, mixed-type, odd-boundary and 4-beat cases, the column bit placement, the window position for a given latency, and truncation by an interrupting read. The same applies to sampling of the latency at the accepting edge and to the absence of windows after writes.

// File: rtl/cbs_pkg.sv
`timescale 1ns/1ps
package cbs_pkg;
    localparam int CA_W      = 10;
    localparam int COL_W     = 11;
    localparam int SINCE_W   = 4;
    localparam int SINCE_SAT = 8;
    localparam int TCCD      = 2;
    localparam logic [CA_W-1:0] CA_NOP = '1;

    typedef enum logic [1:0] {
        BL_4  = 2'b00,
        BL_8  = 2'b01,
        BL_16 = 2'b10
    } blen_e;

    typedef struct packed {
        logic             rd;
        logic [COL_W-1:0] col;
        blen_e            bl;
    } col_req_t;

    typedef struct packed {
        logic            cs_n;
        logic [CA_W-1:0] rise;
        logic [CA_W-1:0] fall;
    } ca_word_t;

    function automatic blen_e decode_bl(input logic [1:0] code);
        case (code)
            2'b00:   return BL_4;
            2'b01:   return BL_8;
            default: return BL_16;
        endcase
    endfunction

    // burst duration in clocks (two beats per clock)
    function automatic logic [SINCE_W-1:0] bl_clocks(input blen_e b);
        case (b)
            BL_4:    return SINCE_W'(2);
            BL_8:    return SINCE_W'(4);
            default: return SINCE_W'(8);
        endcase
    endfunction

    function automatic ca_word_t idle_word();
        ca_word_t w;
        w.cs_n = 1'b1;
        w.rise = CA_NOP;
        w.fall = CA_NOP;
        return w;
    endfunction

    function automatic ca_word_t encode_cmd(input col_req_t r);
        ca_word_t w;
        w.cs_n      = 1'b0;
        w.rise      = '0;
        w.rise[0]   = 1'b1;
        w.rise[1]   = 1'b0;
        w.rise[2]   = r.rd;
        w.rise[6:5] = r.col[1:0];
        w.fall      = {r.col[COL_W-1:2], 1'b0};
        return w;
    endfunction
endpackage

// File: rtl/cbs_tracker.sv
`timescale 1ns/1ps
module cbs_tracker
    import cbs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  col_req_t req,
    input  logic     accept,
    output logic     legal
);
    logic [SINCE_W-1:0] since_q;
    logic               cur_rd_q;
    blen_e              cur_bl_q;

    logic done, ccd_ok, chain_ok;

    always_comb begin
        done     = (since_q >= bl_clocks(cur_bl_q));
        ccd_ok   = (since_q >= SINCE_W'(TCCD));
        chain_ok = (cur_bl_q != BL_4) && (cur_rd_q == req.rd) && !since_q[0];
        legal    = ccd_ok && (done || chain_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q  <= SINCE_W'(SINCE_SAT);
            cur_rd_q <= 1'b0;
            cur_bl_q <= BL_4;
        end else if (accept) begin
            since_q  <= SINCE_W'(1);
            cur_rd_q <= req.rd;
            cur_bl_q <= req.bl;
        end else if (since_q < SINCE_W'(SINCE_SAT)) begin
            since_q  <= since_q + SINCE_W'(1);
        end
    end
endmodule

// File: rtl/cbs_encoder.sv
`timescale 1ns/1ps
module cbs_encoder
    import cbs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  col_req_t req,
    input  logic     accept,
    output ca_word_t word
);
    always_ff @(posedge clk) begin
        if (rst)         word <= idle_word();
        else if (accept) word <= encode_cmd(req);
        else             word <= idle_word();
    end
endmodule

// File: rtl/cbs_rd_window.sv
`timescale 1ns/1ps
module cbs_rd_window
    import cbs_pkg::*;
#(
    parameter  int MAX_RL = 16,
    localparam int RL_W   = $clog2(MAX_RL + 1),
    localparam int DEPTH  = MAX_RL + SINCE_SAT + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept_rd,
    input  logic [RL_W-1:0] rl,
    input  blen_e           bl,
    output logic            rd_valid,
    output logic            preamble
);
    logic [DEPTH-1:0] win_q, win_d;
    logic [RL_W-1:0]  rl_eff;
    int               rl_i, len_i;

    always_comb begin
        if (rl == '0)                   rl_eff = RL_W'(1);
        else if (rl > RL_W'(MAX_RL))    rl_eff = RL_W'(MAX_RL);
        else                            rl_eff = rl;
        rl_i  = int'(rl_eff);
        len_i = int'(bl_clocks(bl));
        win_d = win_q >> 1;
        if (accept_rd) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i >= rl_i) win_d[i] = (i < rl_i + len_i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) win_q <= '0;
        else     win_q <= win_d;
    end

    assign rd_valid = win_q[0];
    assign preamble = win_q[1] & ~win_q[0];
endmodule

// File: rtl/colburst_seq.sv
`timescale 1ns/1ps
module colburst_seq
    import cbs_pkg::*;
#(
    parameter  int MAX_RL = 16,
    localparam int RL_W   = $clog2(MAX_RL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RL_W-1:0]  rl_cfg,
    input  logic             req_valid,
    input  logic             req_is_read,
    input  logic [COL_W-1:0] req_col,
    input  logic [1:0]       req_bl,
    output logic             req_ready,
    output logic             cs_n,
    output logic [CA_W-1:0]  ca_rise,
    output logic [CA_W-1:0]  ca_fall,
    output logic             dqs_preamble,
    output logic             rd_valid
);
    col_req_t req_s;
    ca_word_t word_q;
    logic     legal, accept;

    always_comb begin
        req_s.rd  = req_is_read;
        req_s.col = req_col;
        req_s.bl  = decode_bl(req_bl);
    end

    assign accept    = req_valid & legal;
    assign req_ready = legal;

    cbs_tracker u_track (
        .clk    (clk),
        .rst    (rst),
        .req    (req_s),
        .accept (accept),
        .legal  (legal)
    );

    cbs_encoder u_enc (
        .clk    (clk),
        .rst    (rst),
        .req    (req_s),
        .accept (accept),
        .word   (word_q)
    );

    cbs_rd_window #(.MAX_RL(MAX_RL)) u_win (
        .clk       (clk),
        .rst       (rst),
        .accept_rd (accept & req_is_read),
        .rl        (rl_cfg),
        .bl        (req_s.bl),
        .rd_valid  (rd_valid),
        .preamble  (dqs_preamble)
    );

    assign cs_n    = word_q.cs_n;
    assign ca_rise = word_q.rise;
    assign ca_fall = word_q.fall;
endmodule

// File: rtl/colburst_seq_chk.sv
`timescale 1ns/1ps
module colburst_seq_chk
    import cbs_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_is_read,
    input logic            req_ready,
    input logic            cs_n,
    input logic [CA_W-1:0] ca_rise,
    input logic [CA_W-1:0] ca_fall,
    input logic            dqs_preamble,
    input logic            rd_valid
);
    assert_idle_nop_R2: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (ca_rise == CA_NOP && ca_fall == CA_NOP));

    assert_cmd_code_R3: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> (ca_rise[1:0] == 2'b01));

    assert_issue_type_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!cs_n && ca_rise[2] == $past(req_is_read)));

    assert_spacing_bus_R5: assert property (@(posedge clk) disable iff (rst)
        !cs_n |=> cs_n);

    assert_spacing_ready_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_preamble_next_R10: assert property (@(posedge clk) disable iff (rst)
        dqs_preamble |=> rd_valid);

    assert_preamble_gap_R10: assert property (@(posedge clk) disable iff (rst)
        dqs_preamble |-> !rd_valid);
endmodule

bind colburst_seq colburst_seq_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_is_read  (req_is_read),
    .req_ready    (req_ready),
    .cs_n         (cs_n),
    .ca_rise      (ca_rise),
    .ca_fall      (ca_fall),
    .dqs_preamble (dqs_preamble),
    .rd_valid     (rd_valid)
);

// File: tb/colburst_seq_tb_top.sv
`timescale 1ns/1ps
module colburst_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rl_cfg = 5'd4;
    logic        req_valid = 1'b0;
    logic        req_is_read = 1'b0;
    logic [10:0] req_col = '0;
    logic [1:0]  req_bl = 2'b00;
    logic        req_ready, cs_n, dqs_preamble, rd_valid;
    logic [9:0]  ca_rise, ca_fall;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rdv_hits = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;
    bit exp_win [0:1023];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    colburst_seq dut_i (
        .clk(clk), .rst(rst), .rl_cfg(rl_cfg), .req_valid(req_valid),
        .req_is_read(req_is_read), .req_col(req_col), .req_bl(req_bl),
        .req_ready(req_ready), .cs_n(cs_n), .ca_rise(ca_rise), .ca_fall(ca_fall),
        .dqs_preamble(dqs_preamble), .rd_valid(rd_valid)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int clocks_of(input logic [1:0] bl);
        return (bl == 2'b00) ? 2 : (bl == 2'b01) ? 4 : 8;
    endfunction

    // present a request, wait until accepted; returns in the cycle after the accepting edge
    task automatic send(input logic rd, input logic [10:0] col, input logic [1:0] bl,
                        output int stall);
        int a;
        stall = 0;
        req_valid = 1'b1; req_is_read = rd; req_col = col; req_bl = bl;
        #1;
        while (!req_ready && stall < 50) begin
            @(negedge clk); #1; stall++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        a = cyc;
        if (rd) begin
            for (int j = a + int'(rl_cfg); j < 1024; j++) exp_win[j] = 1'b0;
            for (int j = 0; j < clocks_of(bl); j++) exp_win[a + int'(rl_cfg) + j] = 1'b1;
        end
    endtask

    task automatic check_cmd(input string req, input logic rd, input logic [10:0] col);
        logic [9:0] er, ef;
        er = '0; er[0] = 1'b1; er[2] = rd; er[5] = col[0]; er[6] = col[1];
        ef = {col[10:2], 1'b0};
        check(req, "cs_n low", 32'(cs_n), 32'd0);
        check(req, "ca_rise", 32'(ca_rise), 32'(er));
        check(req, "ca_fall", 32'(ca_fall), 32'(ef));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // per-cycle window model check (R9, R10, R11)
    initial begin
        forever begin
            @(negedge clk); #3;
            if (mon_en) begin
                if (rd_valid) rdv_hits++;
                check("R9", "rd_valid vs window", 32'(rd_valid), 32'(exp_win[cyc]));
                check("R10", "preamble", 32'(dqs_preamble),
                      32'(exp_win[cyc + 1] && !exp_win[cyc]));
            end
        end
    end

    task automatic t_reset();
        check("R1", "cs_n", 32'(cs_n), 32'd1);
        check("R1", "ca_rise", 32'(ca_rise), 32'h3FF);
        check("R1", "ca_fall", 32'(ca_fall), 32'h3FF);
        check("R1", "rd_valid", 32'(rd_valid), 32'd0);
        check("R1", "preamble", 32'(dqs_preamble), 32'd0);
        check("R1", "ready", 32'(req_ready), 32'd1);
    endtask

    task automatic t_write_encode();
        int st, hits;
        send(1'b0, 11'h5A3, 2'b01, st);
        check("R8", "first write stall", 32'(st), 32'd0);
        check_cmd("R3/R4 write", 1'b0, 11'h5A3);
        @(negedge clk);
        check("R2", "cs_n idle", 32'(cs_n), 32'd1);
        check("R2", "ca_rise idle", 32'(ca_rise), 32'h3FF);
        check("R2", "ca_fall idle", 32'(ca_fall), 32'h3FF);
        hits = 0;
        for (int m = 0; m < 12; m++) begin
            @(negedge clk); #4;
            if (rd_valid || dqs_preamble) hits++;
        end
        check("R12", "window after write", 32'(hits), 32'd0);
    endtask

    task automatic t_read_window();
        int st, first, cnt, pre;
        rl_cfg = 5'd5;
        send(1'b1, 11'h2B6, 2'b01, st);
        check_cmd("R3/R4 read", 1'b1, 11'h2B6);
        rl_cfg = 5'd2;  // R13: change after acceptance
        first = -1; cnt = 0; pre = -1;
        for (int m = 1; m <= 14; m++) begin
            @(negedge clk); #4;
            if (rd_valid) begin cnt++; if (first < 0) first = m; end
            if (dqs_preamble && pre < 0) pre = m;
        end
        check("R13", "window start index", 32'(first), 32'd5);
        check("R9", "window length", 32'(cnt), 32'd4);
        check("R10", "preamble index", 32'(pre), 32'd4);
    endtask

    task automatic t_same_interrupt();
        int st;
        rl_cfg = 5'd4;
        rdv_hits = 0;
        send(1'b1, 11'h111, 2'b10, st);
        send(1'b1, 11'h7FE, 2'b01, st);
        check("R7", "same-type interrupt stall", 32'(st), 32'd1);
        check_cmd("R4 interrupt", 1'b1, 11'h7FE);
        idle(16);
        check("R11", "truncated window cycles", 32'(rdv_hits), 32'd6);
    endtask

    task automatic t_mixed();
        int st;
        rl_cfg = 5'd3;
        send(1'b1, 11'h0A5, 2'b01, st);
        send(1'b0, 11'h35A, 2'b01, st);
        check("R6", "mixed-type wait", 32'(st), 32'd3);
        check_cmd("R8 held write issued", 1'b0, 11'h35A);
        idle(12);
    endtask

    task automatic t_odd();
        int st;
        send(1'b0, 11'h001, 2'b11, st);
        idle(2);
        send(1'b0, 11'h400, 2'b01, st);
        check("R7", "odd boundary stall", 32'(st), 32'd1);
        check_cmd("R8 odd", 1'b0, 11'h400);
        idle(10);
    endtask

    task automatic t_bl4();
        int st;
        rl_cfg = 5'd2;
        send(1'b1, 11'h033, 2'b00, st);
        send(1'b1, 11'h066, 2'b00, st);
        check("R5", "BL4 read after read", 32'(st), 32'd1);
        send(1'b0, 11'h099, 2'b00, st);
        check("R6", "BL4 write after read", 32'(st), 32'd1);
        idle(12);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog all-requirements: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < 1024; j++) exp_win[j] = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        t_reset();
        mon_en = 1'b1;
        t_write_encode();
        t_read_window();
        t_same_interrupt();
        t_mixed();
        t_odd();
        t_bl4();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule